// File: doc/BRIEF.md
# Serial NAND Page Operation Controller

This block sits between a host-side request port and two lower-level engines of a serial NAND flash interface. The first is a command phase sequencer that clocks out one single transaction (opcode, address, dummy and data phases). The second is a ready-wait poller that watches the device status until the busy flag clears. A request names one of four operations: device reset, page read, page program or block erase. It carries a row address, a column address, a data length and two options for the program-load step. The controller expands the request into a fixed chain of single transactions and poll phases and issues them strictly one at a time.

Every operation that works on the array is two-staged. The cache and the array are bridged by a transfer step and an execute step. Write-enable precedes the steps that modify the array, and a ready-wait follows the execute. Before each wait, the controller loads the poller with a start delay and a re-poll interval suited to that operation. When the chain ends or is cut short, it raises a one-cycle completion pulse with an outcome code. Page data moves between the sequencer and the host directly and never passes through this block.

Top module: `nand_page_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `seq_valid`, `poll_start` and `done` are 0. A request is taken only in a cycle where `req_valid` and `req_ready` are both 1, and `req_ready` stays 0 from the cycle after acceptance until the cycle after `done`.
- R2: A reset request (`req_op`=0) issues opcode 0xFF with no address, dummy or data (address length 0, dummy length 0, direction 0, length 0). It then runs one ready-wait phase and completes.
- R3: A page-read request (`req_op`=1) issues opcode 0x13 with the row as a 3-byte address, then runs a ready-wait phase. It then issues opcode 0x03 with the column as a 2-byte address, 1 dummy byte, direction 1 (data in), quad 0 and length `req_len`.
- R4: A program request (`req_op`=2) issues opcode 0x06 with no address or data. It then issues the load command with the column as a 2-byte address, direction 2 (data out) and length `req_len`. Next comes opcode 0x10 with the row as a 3-byte address, followed by a ready-wait phase.
- R5: The load opcode is 0x02 for keep=0/quad=0, 0x84 for keep=1/quad=0, 0x32 for keep=0/quad=1 and 0x34 for keep=1/quad=1. `seq_quad` on the load equals `req_quad`.
- R6: An erase request (`req_op`=3) issues opcode 0x06, then opcode 0xD8 with the row as a 3-byte address, then a ready-wait phase.
- R7: Only one lower-level action is outstanding at a time. `seq_valid` is a one-cycle pulse and is never raised again before `seq_done` answers it. `seq_valid` and `poll_start` are never 1 in the same cycle.
- R8: The outcome code on `result` is 0 ok, 1 program fail, 2 erase fail, 3 uncorrectable ECC, 4 timeout. Status bit 3 at the end of a program wait gives 1. Status bit 2 at the end of an erase wait gives 2. A fail bit belonging to another operation has no effect.
- R9: After the page-read wait, status bits [5:4] equal to 2'b10 give result 3 and the cache read is not issued. Any other value of those bits lets the cache read proceed.
- R10: `poll_timeout` together with `poll_done` gives result 4 in the next cycle whatever the status, and no further transaction of that request is issued.
- R11: `done` is a one-cycle pulse, `result` is valid in that cycle, and `req_ready` is 1 in the following cycle.
- R12: Poll delays in clock cycles are microseconds times `CLK_MHZ`. With defaults (125): reset 625/625, read 750/625, program 9375/1875, erase 31250/6250 (start delay / re-poll interval).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_op | input | 2 | 0 reset, 1 page read, 2 program, 3 erase |
| req_row | input | 8*ROW_BYTES | Row (page/block) address |
| req_col | input | 8*COL_BYTES | Column address inside the cache |
| req_len | input | LEN_W | Byte count of the data phase |
| req_keep | input | 1 | Program load keeps the rest of the cache |
| req_quad | input | 1 | Program load uses four data lanes |
| seq_valid | output | 1 | One-cycle transaction strobe to the sequencer |
| seq_opcode | output | 8 | Transaction opcode |
| seq_addr | output | 8*ROW_BYTES | Transaction address, right aligned |
| seq_addr_len | output | 2 | Address bytes |
| seq_dummy_len | output | 2 | Dummy bytes |
| seq_dir | output | 2 | Data phase: 0 none, 1 in, 2 out |
| seq_quad | output | 1 | Data phase on four lanes |
| seq_len | output | LEN_W | Data phase byte count |
| seq_done | input | 1 | Sequencer finished the transaction |
| poll_start | output | 1 | One-cycle start strobe to the poller |
| poll_init_dly | output | DLY_W | Cycles before the first status read |
| poll_step_dly | output | DLY_W | Cycles between status reads |
| poll_done | input | 1 | Poller finished |
| poll_status | input | 8 | Last status byte seen by the poller |
| poll_timeout | input | 1 | Poller gave up (valid with poll_done) |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | Outcome code, valid with done |

## Verification
On every cycle the bound checker enforces the handshake and ordering rules. It checks the single-cycle transaction strobe, that no new transaction starts while one is unanswered, that the sequencer and poller are never started together, the busy window of `req_ready`, the shape of the completion pulse, and the timeout-to-result timing. Correct opcode choice, address and length routing, delay pairing per operation, fail-bit decoding per operation and the early cut-off of a chain are data-dependent. Only the bench's scenarios show these, by comparing the whole recorded transaction list and final code against an independently built expected list.

// File: rtl/nand_page_pkg.sv
package nand_page_pkg;

   typedef enum logic [1:0] {
      OP_RESET = 2'd0,
      OP_READ  = 2'd1,
      OP_PROG  = 2'd2,
      OP_ERASE = 2'd3
   } op_e;

   typedef enum logic [2:0] {
      RES_OK         = 3'd0,
      RES_PROG_FAIL  = 3'd1,
      RES_ERASE_FAIL = 3'd2,
      RES_ECC_UNCOR  = 3'd3,
      RES_TIMEOUT    = 3'd4
   } res_e;

   typedef enum logic [1:0] {
      STEP_CMD  = 2'd0,
      STEP_POLL = 2'd1,
      STEP_END  = 2'd2
   } kind_e;

   typedef enum logic [1:0] {
      ASRC_NONE = 2'd0,
      ASRC_ROW  = 2'd1,
      ASRC_COL  = 2'd2
   } asrc_e;

   typedef enum logic [1:0] {
      DIR_NONE = 2'd0,
      DIR_IN   = 2'd1,
      DIR_OUT  = 2'd2
   } dir_e;

   typedef struct packed {
      kind_e       kind;
      logic [7:0]  opcode;
      asrc_e       asrc;
      dir_e        dir;
      logic        quad;
      logic        use_dummy;
   } step_t;

   // device opcodes
   localparam logic [7:0] OPC_DEV_RESET   = 8'hFF;
   localparam logic [7:0] OPC_WREN        = 8'h06;
   localparam logic [7:0] OPC_ARRAY_READ  = 8'h13;
   localparam logic [7:0] OPC_CACHE_READ  = 8'h03;
   localparam logic [7:0] OPC_LOAD_CLR    = 8'h02;
   localparam logic [7:0] OPC_LOAD_KEEP   = 8'h84;
   localparam logic [7:0] OPC_LOAD4_CLR   = 8'h32;
   localparam logic [7:0] OPC_LOAD4_KEEP  = 8'h34;
   localparam logic [7:0] OPC_PROG_EXEC   = 8'h10;
   localparam logic [7:0] OPC_BLK_ERASE   = 8'hD8;

   localparam logic [1:0] ECC_UNCOR_CODE  = 2'b10;

endpackage

// File: rtl/nand_step_rom.sv
module nand_step_rom
   import nand_page_pkg::*;
#(
   parameter int STEP_W = 3
) (
   input  op_e               op,
   input  logic [STEP_W-1:0] idx,
   input  logic              keep,
   input  logic              quad,
   output step_t             step
);

   logic [7:0] load_opc;

   always_comb begin
      unique case ({quad, keep})
         2'b00:   load_opc = OPC_LOAD_CLR;
         2'b01:   load_opc = OPC_LOAD_KEEP;
         2'b10:   load_opc = OPC_LOAD4_CLR;
         default: load_opc = OPC_LOAD4_KEEP;
      endcase
   end

   always_comb begin
      step = '{kind: STEP_END, opcode: 8'h00, asrc: ASRC_NONE,
               dir: DIR_NONE, quad: 1'b0, use_dummy: 1'b0};
      unique case (op)
         OP_RESET: begin
            if (idx == STEP_W'(0)) begin
               step.kind   = STEP_CMD;
               step.opcode = OPC_DEV_RESET;
            end else if (idx == STEP_W'(1)) begin
               step.kind = STEP_POLL;
            end
         end
         OP_READ: begin
            if (idx == STEP_W'(0)) begin
               step.kind   = STEP_CMD;
               step.opcode = OPC_ARRAY_READ;
               step.asrc   = ASRC_ROW;
            end else if (idx == STEP_W'(1)) begin
               step.kind = STEP_POLL;
            end else if (idx == STEP_W'(2)) begin
               step.kind      = STEP_CMD;
               step.opcode    = OPC_CACHE_READ;
               step.asrc      = ASRC_COL;
               step.dir       = DIR_IN;
               step.use_dummy = 1'b1;
            end
         end
         OP_PROG: begin
            if (idx == STEP_W'(0)) begin
               step.kind   = STEP_CMD;
               step.opcode = OPC_WREN;
            end else if (idx == STEP_W'(1)) begin
               step.kind   = STEP_CMD;
               step.opcode = load_opc;
               step.asrc   = ASRC_COL;
               step.dir    = DIR_OUT;
               step.quad   = quad;
            end else if (idx == STEP_W'(2)) begin
               step.kind   = STEP_CMD;
               step.opcode = OPC_PROG_EXEC;
               step.asrc   = ASRC_ROW;
            end else if (idx == STEP_W'(3)) begin
               step.kind = STEP_POLL;
            end
         end
         default: begin
            if (idx == STEP_W'(0)) begin
               step.kind   = STEP_CMD;
               step.opcode = OPC_WREN;
            end else if (idx == STEP_W'(1)) begin
               step.kind   = STEP_CMD;
               step.opcode = OPC_BLK_ERASE;
               step.asrc   = ASRC_ROW;
            end else if (idx == STEP_W'(2)) begin
               step.kind = STEP_POLL;
            end
         end
      endcase
   end

endmodule

// File: rtl/nand_outcome_eval.sv
module nand_outcome_eval
   import nand_page_pkg::*;
#(
   parameter int ERASE_FAIL_BIT = 2,
   parameter int PROG_FAIL_BIT  = 3,
   parameter int ECC_LSB        = 4
) (
   input  op_e        op,
   input  logic [7:0] status,
   input  logic       timeout,
   output res_e       res
);

   generate
      if (ERASE_FAIL_BIT > 7 || PROG_FAIL_BIT > 7 || ECC_LSB > 6) begin : g_bad_bits
         $error("status bit position out of range");
      end
   endgenerate

   logic unused_status;
   assign unused_status = ^status;

   always_comb begin
      res = RES_OK;
      if (timeout) begin
         res = RES_TIMEOUT;
      end else begin
         unique case (op)
            OP_PROG:  if (status[PROG_FAIL_BIT])  res = RES_PROG_FAIL;
            OP_ERASE: if (status[ERASE_FAIL_BIT]) res = RES_ERASE_FAIL;
            OP_READ:  if (status[ECC_LSB+1 -: 2] == ECC_UNCOR_CODE) res = RES_ECC_UNCOR;
            default:  res = RES_OK;
         endcase
      end
   end

endmodule

// File: rtl/nand_delay_table.sv
module nand_delay_table
   import nand_page_pkg::*;
#(
   parameter int CLK_MHZ      = 125,
   parameter int DLY_W        = 16,
   parameter int RST_INIT_US  = 5,
   parameter int RST_STEP_US  = 5,
   parameter int RD_INIT_US   = 6,
   parameter int RD_STEP_US   = 5,
   parameter int WR_INIT_US   = 75,
   parameter int WR_STEP_US   = 15,
   parameter int ER_INIT_US   = 250,
   parameter int ER_STEP_US   = 50
) (
   input  op_e              op,
   output logic [DLY_W-1:0] init_dly,
   output logic [DLY_W-1:0] step_dly
);

   localparam longint RST_I = longint'(RST_INIT_US) * CLK_MHZ;
   localparam longint RST_S = longint'(RST_STEP_US) * CLK_MHZ;
   localparam longint RD_I  = longint'(RD_INIT_US)  * CLK_MHZ;
   localparam longint RD_S  = longint'(RD_STEP_US)  * CLK_MHZ;
   localparam longint WR_I  = longint'(WR_INIT_US)  * CLK_MHZ;
   localparam longint WR_S  = longint'(WR_STEP_US)  * CLK_MHZ;
   localparam longint ER_I  = longint'(ER_INIT_US)  * CLK_MHZ;
   localparam longint ER_S  = longint'(ER_STEP_US)  * CLK_MHZ;
   localparam longint DLY_MAX = (longint'(1) << DLY_W) - 1;

   generate
      if (RST_I > DLY_MAX || RST_S > DLY_MAX || RD_I > DLY_MAX || RD_S > DLY_MAX ||
          WR_I > DLY_MAX || WR_S > DLY_MAX || ER_I > DLY_MAX || ER_S > DLY_MAX) begin : g_dly_ovf
         $error("poll delay does not fit DLY_W");
      end
      if (CLK_MHZ < 1) begin : g_bad_clk
         $error("CLK_MHZ must be positive");
      end
   endgenerate

   always_comb begin
      unique case (op)
         OP_RESET: begin init_dly = DLY_W'(RST_I); step_dly = DLY_W'(RST_S); end
         OP_READ:  begin init_dly = DLY_W'(RD_I);  step_dly = DLY_W'(RD_S);  end
         OP_PROG:  begin init_dly = DLY_W'(WR_I);  step_dly = DLY_W'(WR_S);  end
         default:  begin init_dly = DLY_W'(ER_I);  step_dly = DLY_W'(ER_S);  end
      endcase
   end

endmodule

// File: rtl/nand_page_ctrl.sv
module nand_page_ctrl
   import nand_page_pkg::*;
#(
   parameter int ROW_BYTES    = 3,
   parameter int COL_BYTES    = 2,
   parameter int DUMMY_BYTES  = 1,
   parameter int LEN_W        = 13,
   parameter int DLY_W        = 16,
   parameter int CLK_MHZ      = 125,
   parameter int RST_INIT_US  = 5,
   parameter int RST_STEP_US  = 5,
   parameter int RD_INIT_US   = 6,
   parameter int RD_STEP_US   = 5,
   parameter int WR_INIT_US   = 75,
   parameter int WR_STEP_US   = 15,
   parameter int ER_INIT_US   = 250,
   parameter int ER_STEP_US   = 50,
   localparam int ROW_W       = 8 * ROW_BYTES,
   localparam int COL_W       = 8 * COL_BYTES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [1:0]       req_op,
   input  logic [ROW_W-1:0] req_row,
   input  logic [COL_W-1:0] req_col,
   input  logic [LEN_W-1:0] req_len,
   input  logic             req_keep,
   input  logic             req_quad,
   output logic             seq_valid,
   output logic [7:0]       seq_opcode,
   output logic [ROW_W-1:0] seq_addr,
   output logic [1:0]       seq_addr_len,
   output logic [1:0]       seq_dummy_len,
   output logic [1:0]       seq_dir,
   output logic             seq_quad,
   output logic [LEN_W-1:0] seq_len,
   input  logic             seq_done,
   output logic             poll_start,
   output logic [DLY_W-1:0] poll_init_dly,
   output logic [DLY_W-1:0] poll_step_dly,
   input  logic             poll_done,
   input  logic [7:0]       poll_status,
   input  logic             poll_timeout,
   output logic             done,
   output logic [2:0]       result
);

   localparam int STEP_W = 3;

   generate
      if (ROW_BYTES > 3 || ROW_BYTES < COL_BYTES || COL_BYTES < 1) begin : g_bad_addr
         $error("address byte counts out of range");
      end
      if (DUMMY_BYTES > 3 || DUMMY_BYTES < 0) begin : g_bad_dummy
         $error("DUMMY_BYTES out of range");
      end
      if (LEN_W < 1) begin : g_bad_len
         $error("LEN_W must be positive");
      end
   endgenerate

   typedef enum logic [2:0] {
      S_IDLE, S_LAUNCH, S_WAIT_SEQ, S_WAIT_POLL, S_FINISH
   } state_e;

   state_e            state_q;
   op_e               op_q;
   logic [ROW_W-1:0]  row_q;
   logic [COL_W-1:0]  col_q;
   logic [LEN_W-1:0]  len_q;
   logic              keep_q;
   logic              quad_q;
   logic [STEP_W-1:0] idx_q;
   res_e              res_q;

   step_t             cur;
   res_e              poll_res;

   nand_step_rom #(.STEP_W(STEP_W)) u_rom (
      .op   (op_q),
      .idx  (idx_q),
      .keep (keep_q),
      .quad (quad_q),
      .step (cur)
   );

   nand_outcome_eval u_eval (
      .op      (op_q),
      .status  (poll_status),
      .timeout (poll_timeout),
      .res     (poll_res)
   );

   nand_delay_table #(
      .CLK_MHZ(CLK_MHZ), .DLY_W(DLY_W),
      .RST_INIT_US(RST_INIT_US), .RST_STEP_US(RST_STEP_US),
      .RD_INIT_US(RD_INIT_US),   .RD_STEP_US(RD_STEP_US),
      .WR_INIT_US(WR_INIT_US),   .WR_STEP_US(WR_STEP_US),
      .ER_INIT_US(ER_INIT_US),   .ER_STEP_US(ER_STEP_US)
   ) u_dly (
      .op       (op_q),
      .init_dly (poll_init_dly),
      .step_dly (poll_step_dly)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         op_q    <= OP_RESET;
         row_q   <= '0;
         col_q   <= '0;
         len_q   <= '0;
         keep_q  <= 1'b0;
         quad_q  <= 1'b0;
         idx_q   <= '0;
         res_q   <= RES_OK;
      end else begin
         unique case (state_q)
            S_IDLE: begin
               if (req_valid) begin
                  op_q    <= op_e'(req_op);
                  row_q   <= req_row;
                  col_q   <= req_col;
                  len_q   <= req_len;
                  keep_q  <= req_keep;
                  quad_q  <= req_quad;
                  idx_q   <= '0;
                  res_q   <= RES_OK;
                  state_q <= S_LAUNCH;
               end
            end
            S_LAUNCH: begin
               unique case (cur.kind)
                  STEP_CMD:  state_q <= S_WAIT_SEQ;
                  STEP_POLL: state_q <= S_WAIT_POLL;
                  default:   state_q <= S_FINISH;
               endcase
            end
            S_WAIT_SEQ: begin
               if (seq_done) begin
                  idx_q   <= idx_q + STEP_W'(1);
                  state_q <= S_LAUNCH;
               end
            end
            S_WAIT_POLL: begin
               if (poll_done) begin
                  res_q <= poll_res;
                  if (poll_res != RES_OK) begin
                     state_q <= S_FINISH;
                  end else begin
                     idx_q   <= idx_q + STEP_W'(1);
                     state_q <= S_LAUNCH;
                  end
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      req_ready  = (state_q == S_IDLE);
      seq_valid  = (state_q == S_LAUNCH) && (cur.kind == STEP_CMD);
      poll_start = (state_q == S_LAUNCH) && (cur.kind == STEP_POLL);
      done       = (state_q == S_FINISH);
      result     = res_q;

      seq_opcode = cur.opcode;
      seq_dir    = cur.dir;
      seq_quad   = cur.quad;
      seq_len    = (cur.dir != DIR_NONE) ? len_q : '0;
      seq_dummy_len = cur.use_dummy ? 2'(DUMMY_BYTES) : 2'd0;

      unique case (cur.asrc)
         ASRC_ROW: begin
            seq_addr     = row_q;
            seq_addr_len = 2'(ROW_BYTES);
         end
         ASRC_COL: begin
            seq_addr     = ROW_W'(col_q);
            seq_addr_len = 2'(COL_BYTES);
         end
         default: begin
            seq_addr     = '0;
            seq_addr_len = 2'd0;
         end
      endcase
   end

endmodule

// File: rtl/nand_page_ctrl_chk.sv
module nand_page_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic       seq_valid,
   input logic       seq_done,
   input logic       poll_start,
   input logic       poll_done,
   input logic       poll_timeout,
   input logic       done,
   input logic [2:0] result
);

   logic seq_open_q;

   always_ff @(posedge clk) begin
      if (!rst_n)         seq_open_q <= 1'b0;
      else if (seq_valid) seq_open_q <= 1'b1;
      else if (seq_done)  seq_open_q <= 1'b0;
   end

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!seq_valid && !poll_start && !done));

   // R1
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R7
   seq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_valid |=> !seq_valid);

   // R7
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(seq_valid && poll_start));

   // R7
   one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_valid |-> !seq_open_q);

   // R10
   timeout_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_done && poll_timeout) |=> (done && result == 3'd4));

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && req_ready));

   // R8
   result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (result <= 3'd4));

endmodule

bind nand_page_ctrl nand_page_ctrl_chk chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .seq_valid    (seq_valid),
   .seq_done     (seq_done),
   .poll_start   (poll_start),
   .poll_done    (poll_done),
   .poll_timeout (poll_timeout),
   .done         (done),
   .result       (result)
);

// File: tb/nand_page_ctrl_tb_top.sv
`timescale 1ns/1ps
module nand_page_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_op = 2'd0;
   logic [23:0] req_row = '0;
   logic [15:0] req_col = '0;
   logic [12:0] req_len = '0;
   logic        req_keep = 1'b0;
   logic        req_quad = 1'b0;
   logic        seq_valid;
   logic [7:0]  seq_opcode;
   logic [23:0] seq_addr;
   logic [1:0]  seq_addr_len;
   logic [1:0]  seq_dummy_len;
   logic [1:0]  seq_dir;
   logic        seq_quad;
   logic [12:0] seq_len;
   logic        seq_done = 1'b0;
   logic        poll_start;
   logic [15:0] poll_init_dly;
   logic [15:0] poll_step_dly;
   logic        poll_done = 1'b0;
   logic [7:0]  poll_status = '0;
   logic        poll_timeout = 1'b0;
   logic        done;
   logic [2:0]  result;

   always #4 clk = ~clk;

   nand_page_ctrl dut_i (.*);

   typedef struct packed {
      logic        is_poll;
      logic [7:0]  opc;
      logic [23:0] addr;
      logic [1:0]  alen;
      logic [1:0]  dum;
      logic [1:0]  dir;
      logic        quad;
      logic [12:0] len;
      logic [15:0] idly;
      logic [15:0] sdly;
   } txn_t;

   txn_t exp_q[$];
   txn_t got_q[$];
   int   n_chk = 0;
   int   n_fail = 0;
   bit   finished = 0;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // per-cycle reference of the busy window and transaction discipline
   bit mb_busy = 0, prev_ready = 0, prev_done = 0, seq_open = 0;
   always @(posedge clk) begin
      #2;
      if (!rst_n) begin
         mb_busy = 0; prev_ready = 0; prev_done = 0; seq_open = 0;
      end else begin
         if (prev_done) mb_busy = 0;
         if (req_valid && prev_ready) mb_busy = 1;
         check(req_ready == !mb_busy, "R1", "req_ready vs busy model", req_ready, !mb_busy);
         check(!(seq_valid && poll_start), "R7", "seq and poll started together",
               {seq_valid, poll_start}, 2'b00);
         if (seq_done) seq_open = 0;
         if (seq_valid) begin
            check(!seq_open, "R7", "transaction issued while one open", 1, 0);
            seq_open = 1;
         end
         prev_ready = req_ready;
         prev_done  = done;
      end
   end

   function automatic txn_t mk_cmd(input logic [7:0] opc, input logic [23:0] addr,
                                   input int alen, input int dum, input int dir,
                                   input bit quad, input logic [12:0] len);
      txn_t t;
      t = '0;
      t.opc = opc; t.addr = addr; t.alen = 2'(alen); t.dum = 2'(dum);
      t.dir = 2'(dir); t.quad = quad; t.len = len;
      return t;
   endfunction

   function automatic txn_t mk_poll(input int idly, input int sdly);
      txn_t t;
      t = '0;
      t.is_poll = 1'b1; t.idly = 16'(idly); t.sdly = 16'(sdly);
      return t;
   endfunction

   // expected chain built from the requirements
   task automatic build_expected(input int op, input logic [23:0] row, input logic [15:0] col,
                                 input logic [12:0] len, input bit keep, input bit quad,
                                 input logic [7:0] st, input bit tmo, output int res);
      logic [7:0] lopc;
      exp_q.delete();
      res = 0;
      case (op)
         0: begin
            exp_q.push_back(mk_cmd(8'hFF, 0, 0, 0, 0, 0, 0));
            exp_q.push_back(mk_poll(625, 625));
            res = tmo ? 4 : 0;
         end
         1: begin
            exp_q.push_back(mk_cmd(8'h13, row, 3, 0, 0, 0, 0));
            exp_q.push_back(mk_poll(750, 625));
            if (tmo) res = 4;
            else if (st[5:4] == 2'b10) res = 3;
            else exp_q.push_back(mk_cmd(8'h03, {8'h00, col}, 2, 1, 1, 0, len));
         end
         2: begin
            lopc = quad ? (keep ? 8'h34 : 8'h32) : (keep ? 8'h84 : 8'h02);
            exp_q.push_back(mk_cmd(8'h06, 0, 0, 0, 0, 0, 0));
            exp_q.push_back(mk_cmd(lopc, {8'h00, col}, 2, 0, 2, quad, len));
            exp_q.push_back(mk_cmd(8'h10, row, 3, 0, 0, 0, 0));
            exp_q.push_back(mk_poll(9375, 1875));
            res = tmo ? 4 : (st[3] ? 1 : 0);
         end
         default: begin
            exp_q.push_back(mk_cmd(8'h06, 0, 0, 0, 0, 0, 0));
            exp_q.push_back(mk_cmd(8'hD8, row, 3, 0, 0, 0, 0));
            exp_q.push_back(mk_poll(31250, 6250));
            res = tmo ? 4 : (st[2] ? 2 : 0);
         end
      endcase
   endtask

   task automatic run_op(input string tag, input int op, input logic [23:0] row,
                         input logic [15:0] col, input logic [12:0] len, input bit keep,
                         input bit quad, input logic [7:0] st, input bit tmo);
      int  exp_res;
      int  sd_cnt = 0;
      int  pd_cnt = 0;
      bit  fin = 0;
      int  got_res = -1;
      txn_t t;
      build_expected(op, row, col, len, keep, quad, st, tmo, exp_res);
      got_q.delete();
      @(negedge clk);
      req_op = 2'(op); req_row = row; req_col = col; req_len = len;
      req_keep = keep; req_quad = quad; poll_status = st;
      req_valid = 1'b1;
      for (int cyc = 0; cyc < 400 && !fin; cyc++) begin
         @(negedge clk);
         req_valid = 1'b0; seq_done = 1'b0; poll_done = 1'b0; poll_timeout = 1'b0;
         if (sd_cnt > 0) begin sd_cnt--; if (sd_cnt == 0) seq_done = 1'b1; end
         if (pd_cnt > 0) begin
            pd_cnt--;
            if (pd_cnt == 0) begin poll_done = 1'b1; poll_timeout = tmo; end
         end
         if (seq_valid) begin
            t = '0;
            t.opc = seq_opcode; t.addr = seq_addr; t.alen = seq_addr_len;
            t.dum = seq_dummy_len; t.dir = seq_dir; t.quad = seq_quad; t.len = seq_len;
            got_q.push_back(t);
            sd_cnt = 2;
         end
         if (poll_start) begin
            got_q.push_back(mk_poll(int'(poll_init_dly), int'(poll_step_dly)));
            pd_cnt = 3;
         end
         if (done) begin
            got_res = int'(result);
            fin = 1;
         end
      end
      check(fin, tag, "completion seen", fin, 1);
      check(got_res == exp_res, tag, "result code", got_res, exp_res);
      check(got_q.size() == exp_q.size(), tag, "transaction count", got_q.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
         if (exp_q[i].is_poll)
            check(got_q[i] == exp_q[i], "R12", "poll delay pair", got_q[i], exp_q[i]);
         else
            check(got_q[i] == exp_q[i], tag, "transaction fields", got_q[i], exp_q[i]);
      end
      @(negedge clk);
      // R11: single-cycle completion, ready again
      check(!done && req_ready, "R11", "done pulse width / ready after",
            {done, req_ready}, 2'b01);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(req_ready && !seq_valid && !poll_start && !done, "R1", "idle after reset",
            {req_ready, seq_valid, poll_start, done}, 4'b1000);

      run_op("R2", 0, 24'h0, 16'h0, 13'd0, 0, 0, 8'h00, 0);
      run_op("R3", 1, 24'h012345, 16'h0123, 13'd2048, 0, 0, 8'h00, 0);
      run_op("R4", 2, 24'h00A0B1, 16'h0040, 13'd512, 0, 0, 8'h00, 0);
      run_op("R5", 2, 24'h00A0B2, 16'h0080, 13'd64, 1, 0, 8'h00, 0);
      run_op("R5", 2, 24'h00A0B3, 16'h0100, 13'd16, 0, 1, 8'h00, 0);
      run_op("R5", 2, 24'h00A0B4, 16'h0004, 13'd8, 1, 1, 8'h00, 0);
      run_op("R6", 3, 24'h03FFC0, 16'h0000, 13'd0, 0, 0, 8'h00, 0);
      // R8: fail bits of each array operation, and of the wrong operation
      run_op("R8", 2, 24'h000001, 16'h0000, 13'd4, 1, 0, 8'h08, 0);
      run_op("R8", 3, 24'h000040, 16'h0000, 13'd0, 0, 0, 8'h04, 0);
      run_op("R8", 3, 24'h000080, 16'h0000, 13'd0, 0, 0, 8'h08, 0);
      run_op("R8", 2, 24'h000002, 16'h0002, 13'd4, 0, 0, 8'h04, 0);
      // R9: uncorrectable ECC stops the cache read; correctable does not
      run_op("R9", 1, 24'h000777, 16'h0800, 13'd64, 0, 0, 8'h20, 0);
      run_op("R9", 1, 24'h000778, 16'h0010, 13'd32, 0, 0, 8'h10, 0);
      run_op("R9", 1, 24'h000779, 16'h0010, 13'd32, 0, 0, 8'h30, 0);
      // R10: timeout wins over status and cuts the chain
      run_op("R10", 1, 24'h000100, 16'h0020, 13'd32, 0, 0, 8'h20, 1);
      run_op("R10", 3, 24'h000200, 16'h0000, 13'd0, 0, 0, 8'h04, 1);
      run_op("R10", 0, 24'h0, 16'h0, 13'd0, 0, 0, 8'h00, 1);

      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_fail++;
         $display("FAIL R1 watchdog expired: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule